// File: doc/BRIEF.md
# Truth-Table Logic Unit with Magnitude Compare

This block takes two operands and a 4-bit function code and returns a bitwise result together with an unsigned magnitude comparison. The function code is read literally as the truth table of a two-input Boolean function. At each bit position the operand bits pick one of the four table entries through a 4-to-1 multiplexer, so choosing the code chooses among all sixteen two-input functions. No gate is dedicated to any single function.

The comparison reuses the same multiplexer cell. A chain of multiplexers runs from the least significant bit upward. Each stage carries a three-valued state (equal, less, greater) and is indexed by the operand bits at its position. When the bits match, the stage passes the state on unchanged. When A is 0 and B is 1, it forces "less". When A is 1 and B is 0, it forces "greater". The chain starts in "equal", so the most significant differing bit decides the outcome.

Operands enter on a valid/ready input stream and results leave on a valid/ready output stream through one register stage. An input transfer happens on a clock edge where `in_valid` and `in_ready` are both high. The block raises `in_ready` whenever its output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the held result stays unchanged and `in_ready` stays low.

Top module: `truth_logic_unit`

## Requirements
- R1: For every bit i, `out_res[i]` equals `in_func[{in_a[i], in_b[i]}]` of the accepted transfer. Bit 0 of `in_func` is the entry for a=0,b=0, bit 1 for a=0,b=1, bit 2 for a=1,b=0, and bit 3 for a=1,b=1.
- R2: Each of the 16 codes yields its own Boolean function. For example, 4'b0000 gives all zeros, 4'b1111 gives all ones, 4'b1000 gives AND, 4'b1110 gives OR, 4'b0110 gives XOR and 4'b0011 gives NOT A.
- R3: Whenever `out_valid` is high, exactly one of `out_eq`, `out_lt` and `out_gt` is high.
- R4: `out_eq`, `out_lt` and `out_gt` report A==B, A<B and A>B, with both operands treated as unsigned.
- R5: The most significant bit position where the operands differ decides the comparison, whatever the lower bits hold.
- R6: An input transfer appears on the output, with `out_valid` high, after the next rising clock edge.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output holds its value.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: If `out_ready` is high and no transfer is accepted, `out_valid` is low after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input operands and code are valid |
| in_ready | output | 1 | Block can accept an input transfer |
| in_a | input | WIDTH | Operand A |
| in_b | input | WIDTH | Operand B |
| in_func | input | 4 | Truth-table function code |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_res | output | WIDTH | Bitwise result |
| out_eq | output | 1 | A equals B |
| out_lt | output | 1 | A less than B (unsigned) |
| out_gt | output | 1 | A greater than B (unsigned) |

## Verification
The bench builds two copies of the block. The first uses the default width of 16 and is driven with directed operand patterns, all sixteen codes, compare cases that differ only in the top bit or only in the bottom bit, and stalls on the output stream. The second uses WIDTH set to 4, which makes it practical to sweep every code against every operand pair (4096 transfers). That sweep covers every truth-table entry and every possible compare-chain path. The small width is what makes an exhaustive check reachable.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  localparam int FUNC_W = 4;
  localparam int CMP_W  = 2;
  // compare state encoding carried along the chain
  localparam logic [CMP_W-1:0] CMP_EQ = 2'b00;
  localparam logic [CMP_W-1:0] CMP_LT = 2'b01;
  localparam logic [CMP_W-1:0] CMP_GT = 2'b10;

  function automatic logic [2:0] cmp_flags(input logic [CMP_W-1:0] st);
    // returns {eq, lt, gt}
    case (st)
      CMP_LT:  cmp_flags = 3'b010;
      CMP_GT:  cmp_flags = 3'b001;
      default: cmp_flags = 3'b100;
    endcase
  endfunction
endpackage

// File: rtl/tlu_mux4.sv
module tlu_mux4 #(
  parameter int W = 1
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  input  logic [W-1:0] d2,
  input  logic [W-1:0] d3,
  output logic [W-1:0] y
);
  always_comb begin
    case (sel)
      2'd0:    y = d0;
      2'd1:    y = d1;
      2'd2:    y = d2;
      default: y = d3;
    endcase
  end
endmodule

// File: rtl/tlu_bitwise.sv
module tlu_bitwise
  import tlu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]  a,
  input  logic [WIDTH-1:0]  b,
  input  logic [FUNC_W-1:0] func,
  output logic [WIDTH-1:0]  res
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    tlu_mux4 #(.W(1)) u_mux (
      .sel ({a[i], b[i]}),
      .d0  (func[0]),
      .d1  (func[1]),
      .d2  (func[2]),
      .d3  (func[3]),
      .y   (res[i])
    );
  end
endmodule

// File: rtl/tlu_cmp_chain.sv
module tlu_cmp_chain
  import tlu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             eq,
  output logic             lt,
  output logic             gt
);
  logic [CMP_W-1:0] stage [WIDTH+1];

  assign stage[0] = CMP_EQ;

  // LSB to MSB: a differing higher bit overwrites any lower decision
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    tlu_mux4 #(.W(CMP_W)) u_mux (
      .sel ({a[i], b[i]}),
      .d0  (stage[i]),
      .d1  (CMP_LT),
      .d2  (CMP_GT),
      .d3  (stage[i]),
      .y   (stage[i+1])
    );
  end

  logic [2:0] flags;
  assign flags = cmp_flags(stage[WIDTH]);
  assign eq = flags[2];
  assign lt = flags[1];
  assign gt = flags[0];
endmodule

// File: rtl/tlu_out_stage.sv
module tlu_out_stage #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [WIDTH-1:0] up_res,
  input  logic             up_eq,
  input  logic             up_lt,
  input  logic             up_gt,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [WIDTH-1:0] dn_res,
  output logic             dn_eq,
  output logic             dn_lt,
  output logic             dn_gt
);
  logic take;
  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_res   <= '0;
      dn_eq    <= 1'b1;
      dn_lt    <= 1'b0;
      dn_gt    <= 1'b0;
    end else begin
      if (up_ready) dn_valid <= up_valid;
      if (take) begin
        dn_res <= up_res;
        dn_eq  <= up_eq;
        dn_lt  <= up_lt;
        dn_gt  <= up_gt;
      end
    end
  end
endmodule

// File: rtl/truth_logic_unit.sv
module truth_logic_unit
  import tlu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WIDTH-1:0]  in_a,
  input  logic [WIDTH-1:0]  in_b,
  input  logic [FUNC_W-1:0] in_func,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDTH-1:0]  out_res,
  output logic              out_eq,
  output logic              out_lt,
  output logic              out_gt
);
  logic [WIDTH-1:0] res_c;
  logic             eq_c, lt_c, gt_c;

  tlu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a    (in_a),
    .b    (in_b),
    .func (in_func),
    .res  (res_c)
  );

  tlu_cmp_chain #(.WIDTH(WIDTH)) u_cmp (
    .a  (in_a),
    .b  (in_b),
    .eq (eq_c),
    .lt (lt_c),
    .gt (gt_c)
  );

  tlu_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_res   (res_c),
    .up_eq    (eq_c),
    .up_lt    (lt_c),
    .up_gt    (gt_c),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_res   (out_res),
    .dn_eq    (out_eq),
    .dn_lt    (out_lt),
    .dn_gt    (out_gt)
  );
endmodule

// File: rtl/tlu_checker.sv
module tlu_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic [3:0]       in_func,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_res,
  input logic             out_eq,
  input logic             out_lt,
  input logic             out_gt
);
  function automatic logic [WIDTH-1:0] table_apply(input logic [WIDTH-1:0] x,
                                                   input logic [WIDTH-1:0] y,
                                                   input logic [3:0] f);
    logic [WIDTH-1:0] r;
    for (int k = 0; k < WIDTH; k++) r[k] = f[{x[k], y[k]}];
    return r;
  endfunction

  AST_RESULT_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_res == table_apply($past(in_a), $past(in_b), $past(in_func)))); // R1

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({out_eq, out_lt, out_gt}) == 1)); // R3

  AST_CMP_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_lt == ($past(in_a) < $past(in_b)) && out_gt == ($past(in_a) > $past(in_b)))); // R4

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R6

  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_eq) && $stable(out_lt) && $stable(out_gt))); // R7

  AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !in_valid) |=> !out_valid); // R9
endmodule

bind truth_logic_unit tlu_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_a      (in_a),
  .in_b      (in_b),
  .in_func   (in_func),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_res   (out_res),
  .out_eq    (out_eq),
  .out_lt    (out_lt),
  .out_gt    (out_gt)
);

// File: tb/truth_logic_unit_tb.sv
`timescale 1ns/1ps
module truth_logic_unit_tb;
  localparam int W  = 16;
  localparam int WS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          in_valid = 1'b0, out_ready = 1'b1;
  logic [W-1:0]  in_a = '0, in_b = '0;
  logic [3:0]    in_func = '0;
  logic          in_ready, out_valid, out_eq, out_lt, out_gt;
  logic [W-1:0]  out_res;

  logic          s_in_valid = 1'b0, s_out_ready = 1'b1;
  logic [WS-1:0] s_a = '0, s_b = '0;
  logic [3:0]    s_func = '0;
  logic          s_in_ready, s_out_valid, s_eq, s_lt, s_gt;
  logic [WS-1:0] s_res;

  truth_logic_unit #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_func(in_func), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_eq(out_eq),
    .out_lt(out_lt), .out_gt(out_gt));

  truth_logic_unit #(.WIDTH(WS)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_ready(s_in_ready),
    .in_a(s_a), .in_b(s_b), .in_func(s_func), .out_valid(s_out_valid),
    .out_ready(s_out_ready), .out_res(s_res), .out_eq(s_eq),
    .out_lt(s_lt), .out_gt(s_gt));

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_fn(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic [3:0] f);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = f[{x[k], y[k]}];
    return r;
  endfunction

  // one transfer on the wide DUT; results visible at the following negedge
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] f);
    @(negedge clk);
    in_a = a; in_b = b; in_func = f; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_full(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] f,
                            input string req);
    logic [2:0] exp_flags;
    send(a, b, f);
    exp_flags = {a == b, a < b, a > b};
    chk(out_valid == 1'b1, req, "out_valid", out_valid, 1);
    chk(out_res == ref_fn(a, b, f), req, "out_res", out_res, ref_fn(a, b, f));
    chk({out_eq, out_lt, out_gt} == exp_flags, req, "flags", {out_eq, out_lt, out_gt}, exp_flags);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R8", "in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_named_codes();
    logic [W-1:0] a = 16'hF0CC, b = 16'hAA0F;
    send(a, b, 4'b0000); chk(out_res == 16'h0000, "R2", "const0", out_res, 16'h0000);
    send(a, b, 4'b1111); chk(out_res == 16'hFFFF, "R2", "const1", out_res, 16'hFFFF);
    send(a, b, 4'b1000); chk(out_res == (a & b), "R2", "and", out_res, a & b);
    send(a, b, 4'b1110); chk(out_res == (a | b), "R2", "or", out_res, a | b);
    send(a, b, 4'b0110); chk(out_res == (a ^ b), "R2", "xor", out_res, a ^ b);
    send(a, b, 4'b0011); chk(out_res == ~a, "R2", "not a", out_res, ~a);
    send(a, b, 4'b0111); chk(out_res == ~(a & b), "R2", "nand", out_res, ~(a & b));
  endtask

  task automatic t_all_codes();
    for (int f = 0; f < 16; f++) begin
      check_full(16'h5A3C, 16'h33C5, f[3:0], "R1");
      check_full(16'hFFFF, 16'h0000, f[3:0], "R1");
    end
  endtask

  task automatic t_compare();
    check_full(16'h1234, 16'h1234, 4'b1000, "R4");
    check_full(16'h0001, 16'hFFFF, 4'b1000, "R4");
    check_full(16'h8000, 16'h7FFF, 4'b1000, "R4");  // unsigned: 0x8000 is larger
    check_full(16'h0000, 16'h0000, 4'b0110, "R4");
    check_full(16'h8000, 16'h0FFF, 4'b0110, "R5");  // top bit wins over all lower
    check_full(16'h7FFF, 16'hFFFE, 4'b0110, "R5");
    check_full(16'hABCD, 16'hABCC, 4'b0110, "R5");  // only LSB differs
    check_full(16'h4000, 16'h3FFF, 4'b0110, "R3");
  endtask

  task automatic t_backpressure();
    logic [W-1:0] held;
    @(negedge clk);
    in_a = 16'h00FF; in_b = 16'h0F0F; in_func = 4'b1000; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R6", "valid after one edge", out_valid, 1);
    held = out_res;
    chk(held == 16'h000F, "R6", "res after one edge", held, 16'h000F);
    in_a = 16'hFFFF; in_b = 16'h0000; in_func = 4'b1110;  // new beat offered, must wait
    @(negedge clk);
    chk(in_ready == 1'b0, "R7", "in_ready during stall", in_ready, 0);
    @(negedge clk);
    chk(out_res == 16'h000F, "R7", "res held during stall", out_res, 16'h000F);
    chk(out_lt == 1'b1, "R7", "lt held during stall", out_lt, 1);
    out_ready = 1'b1;  // drain old and take new at same edge
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R6", "valid for second beat", out_valid, 1);
    chk(out_res == 16'hFFFF, "R6", "second beat res", out_res, 16'hFFFF);
    chk(out_gt == 1'b1, "R6", "second beat gt", out_gt, 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "drained when idle", out_valid, 0);
    chk(in_ready == 1'b1, "R9", "ready when idle", in_ready, 1);
  endtask

  task automatic t_exhaustive_small();
    int bad = 0;
    for (int f = 0; f < 16; f++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          logic [WS-1:0] er;
          @(negedge clk);
          s_a = a[WS-1:0]; s_b = b[WS-1:0]; s_func = f[3:0]; s_in_valid = 1'b1;
          @(negedge clk);
          s_in_valid = 1'b0;
          for (int k = 0; k < WS; k++) er[k] = f[{a[k], b[k]}];
          if (!s_out_valid || s_res !== er ||
              {s_eq, s_lt, s_gt} !== {a == b, a < b, a > b}) begin
            if (bad == 0)
              chk(1'b0, "R1", "small sweep res/flags", {s_res, s_eq, s_lt, s_gt},
                  {er, a == b, a < b, a > b});
            bad++;
          end
        end
    chk(bad == 0, "R5", "small sweep mismatches", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_named_codes();
    t_all_codes();
    t_compare();
    t_backpressure();
    t_exhaustive_small();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule